// File: doc/BRIEF.md
# Memory Map Control Register with Fixed-Window Translation

This block holds an 8-bit control register that governs whether on-chip nonvolatile memory is visible to the CPU. It also translates the CPU's fixed 16 KiB window (local 0x4000–0x7FFF) into a 23-bit global address. Three bits are implemented. The emulated-memory enable comes only from a strapped input at reset. The memory enable also resets from a strap. The high-half-only control resets to 0. The memory enable and the high-half-only control can be rewritten without limit in special modes, but only once per reset in normal and emulation modes.

The translation is purely combinational from the current register bits. With the high-half control clear, the window maps onto the internal fixed page at global bank 0x7F. With it set, the window is redirected to global bank 0x14 and flagged as external. In emulation mode, register reads return the data presented by the external bus, and register writes are mirrored onto that bus as well as updating the internal bits.

Top module: `memmap_ctrl`

## Requirements
- R1: The register answers at local address 0x0013. Outside emulation mode a read there returns {5'b00000, emem, hh, nvm}, with emem in bit 2, hh in bit 1 and nvm in bit 0. A read of any other address returns 0x00.
- R2: Reset is synchronous and active low. After reset, emem equals strap_emem_i, nvm equals strap_nvm_i, hh is 0, and both write-once chances are restored.
- R3: Bit 2 (emem) never changes through a register write, in any mode.
- R4: In normal mode (opmode_i = 2'b00) and emulation mode (2'b01), the first write to 0x0013 after reset loads hh from data bit 1 and nvm from data bit 0. Every later write to that address is ignored until the next reset.
- R5: In special modes (opmode_i[1] = 1), every write to 0x0013 loads hh and nvm. Such writes do not use up the single write allowed in normal or emulation mode.
- R6: win_hit_o is 1 exactly when cpu_addr_i lies in 0x4000–0x7FFF. Outside the window, glob_addr_o is 0 and win_ext_o is 0.
- R7: With hh = 0 and nvm = 1, a window address A gives glob_addr_o = {7'h7F, A} and win_ext_o = 0, in the same cycle as A.
- R8: With hh = 1, a window address A gives glob_addr_o = {7'h14, A} and win_ext_o = 1.
- R9: With hh = 0 and nvm = 0, a window address A gives glob_addr_o = {7'h7F, A} and win_ext_o = 1, so no internal select is made.
- R10: In emulation mode, a read of 0x0013 returns ext_rdata_i instead of the internal bits.
- R11: ext_wr_o is 1 exactly when reg_wr_i is 1 at address 0x0013 in emulation mode. The internal bits are still updated by that write under R4, and ext_wdata_o carries reg_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opmode_i | input | 2 | 00 normal, 01 emulation, 1x special |
| strap_emem_i | input | 1 | Reset value of the emulated-memory enable |
| strap_nvm_i | input | 1 | Reset value of the memory enable |
| reg_addr_i | input | 16 | Register bus address |
| reg_wr_i | input | 1 | Register bus write strobe |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Register bus read data (combinational) |
| ext_rdata_i | input | 8 | External bus read data used in emulation mode |
| ext_wr_o | output | 1 | Register write mirrored to the external bus |
| ext_wdata_o | output | 8 | Data for the mirrored write |
| cpu_addr_i | input | 16 | CPU local address to translate |
| win_hit_o | output | 1 | Address lies in the fixed window |
| glob_addr_o | output | 23 | Translated global address |
| win_ext_o | output | 1 | Window access is routed externally |

## Verification
The bench targets the write-once boundary in several ways. It writes repeatedly in normal and emulation modes, and interleaves special-mode writes before and after the single allowed write. A design that let special writes consume the chance would freeze hh and nvm too early. A design that let second writes through would show the newer data. The bench writes data with bit 2 set under both strap values to catch a design that lets software touch emem. It probes the window edges 0x3FFF, 0x4000, 0x7FFF and 0x8000 in all three hh/nvm combinations. An off-by-one limit or a swapped bank would show up there as a wrong hit, bank or external flag. The bench also checks that emulation reads come from the external bus and that the mirrored write strobe never appears in other modes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam logic [1:0] OPM_NORMAL = 2'b00;
    localparam logic [1:0] OPM_EMUL   = 2'b01;

    // Number of bits governed by the write-once rule (hh, nvm)
    localparam int WO_BITS = 2;

    typedef struct packed {
        logic emem;   // bit 2, strap-only
        logic hh;     // bit 1, high-half-only control
        logic nvm;    // bit 0, memory enable
    } ctl_t;

    function automatic logic opm_special(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic opm_emul(input logic [1:0] m);
        return m == OPM_EMUL;
    endfunction

endpackage

// File: rtl/memmap_regs.sv
module memmap_regs
    import memmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         opmode_i,
    input  logic               strap_emem_i,
    input  logic               strap_nvm_i,
    input  logic               wr_hit_i,
    input  logic [WO_BITS-1:0] wdata_i,
    output ctl_t               ctl_o,
    output logic [WO_BITS-1:0] done_o
);

    typedef struct packed {
        ctl_t               ctl;
        logic [WO_BITS-1:0] done;
    } state_t;

    state_t             s_d, s_q;
    logic [WO_BITS-1:0] wo_cur;
    logic [WO_BITS-1:0] wo_nxt;
    logic [WO_BITS-1:0] done_nxt;

    assign wo_cur = {s_q.ctl.hh, s_q.ctl.nvm};

    // Per-bit write permission: special modes write freely and leave the
    // sticky flag alone; other modes write only while the flag is clear.
    for (genvar i = 0; i < WO_BITS; i++) begin : g_wo
        always_comb begin
            wo_nxt[i]   = wo_cur[i];
            done_nxt[i] = s_q.done[i];
            if (wr_hit_i) begin
                if (opm_special(opmode_i)) begin
                    wo_nxt[i] = wdata_i[i];
                end else if (!s_q.done[i]) begin
                    wo_nxt[i]   = wdata_i[i];
                    done_nxt[i] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.ctl.hh   = wo_nxt[1];
        s_d.ctl.nvm  = wo_nxt[0];
        s_d.done     = done_nxt;
        if (!rst_n) begin
            s_d.ctl.emem = strap_emem_i;
            s_d.ctl.hh   = 1'b0;
            s_d.ctl.nvm  = strap_nvm_i;
            s_d.done     = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ctl_o  = s_q.ctl;
    assign done_o = s_q.done;

endmodule

// File: rtl/memmap_xlate.sv
module memmap_xlate #(
    parameter int                   AW       = 16,
    parameter int                   GAW      = 23,
    parameter logic [AW-1:0]        WIN_BASE = 16'h4000,
    parameter logic [AW-1:0]        WIN_LAST = 16'h7FFF,
    parameter logic [GAW-AW-1:0]    INT_BANK = 7'h7F,
    parameter logic [GAW-AW-1:0]    EXT_BANK = 7'h14
) (
    input  logic [AW-1:0]  cpu_addr_i,
    input  logic           hh_i,
    input  logic           nvm_i,
    output logic           hit_o,
    output logic [GAW-1:0] glob_o,
    output logic           ext_o
);

    localparam int BANK_W = GAW - AW;

    logic [BANK_W-1:0] bank;

    always_comb begin
        hit_o  = (cpu_addr_i >= WIN_BASE) && (cpu_addr_i <= WIN_LAST);
        bank   = hh_i ? EXT_BANK : INT_BANK;
        glob_o = '0;
        ext_o  = 1'b0;
        if (hit_o) begin
            glob_o = {bank, cpu_addr_i};
            ext_o  = hh_i || !nvm_i;
        end
    end

endmodule

// File: rtl/memmap_rdpath.sv
module memmap_rdpath
    import memmap_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = 16'h0013
) (
    input  logic [AW-1:0] reg_addr_i,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    input  logic [1:0]    opmode_i,
    input  ctl_t          ctl_i,
    input  logic [DW-1:0] ext_rdata_i,
    output logic          wr_hit_o,
    output logic [DW-1:0] rdata_o,
    output logic          ext_wr_o,
    output logic [DW-1:0] ext_wdata_o
);

    localparam int CTL_W = $bits(ctl_t);

    logic sel;

    always_comb begin
        sel         = (reg_addr_i == REG_ADDR);
        wr_hit_o    = sel && reg_wr_i;
        ext_wr_o    = wr_hit_o && opm_emul(opmode_i);
        ext_wdata_o = reg_wdata_i;
        rdata_o     = '0;
        if (sel) begin
            if (opm_emul(opmode_i)) begin
                rdata_o = ext_rdata_i;
            end else begin
                rdata_o = {{(DW-CTL_W){1'b0}}, ctl_i};
            end
        end
    end

endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
    import memmap_pkg::*;
#(
    parameter int                AW       = 16,
    parameter int                DW       = 8,
    parameter int                GAW      = 23,
    parameter logic [AW-1:0]     REG_ADDR = 16'h0013,
    parameter logic [AW-1:0]     WIN_BASE = 16'h4000,
    parameter logic [AW-1:0]     WIN_LAST = 16'h7FFF,
    parameter logic [GAW-AW-1:0] INT_BANK = 7'h7F,
    parameter logic [GAW-AW-1:0] EXT_BANK = 7'h14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     opmode_i,
    input  logic           strap_emem_i,
    input  logic           strap_nvm_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic           reg_wr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic [DW-1:0]  ext_rdata_i,
    output logic           ext_wr_o,
    output logic [DW-1:0]  ext_wdata_o,
    input  logic [AW-1:0]  cpu_addr_i,
    output logic           win_hit_o,
    output logic [GAW-1:0] glob_addr_o,
    output logic           win_ext_o
);

    ctl_t               ctl_q;
    logic [WO_BITS-1:0] done_q;
    logic               wr_hit;

    memmap_rdpath #(
        .AW       (AW),
        .DW       (DW),
        .REG_ADDR (REG_ADDR)
    ) u_rd (
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .opmode_i    (opmode_i),
        .ctl_i       (ctl_q),
        .ext_rdata_i (ext_rdata_i),
        .wr_hit_o    (wr_hit),
        .rdata_o     (reg_rdata_o),
        .ext_wr_o    (ext_wr_o),
        .ext_wdata_o (ext_wdata_o)
    );

    memmap_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .opmode_i     (opmode_i),
        .strap_emem_i (strap_emem_i),
        .strap_nvm_i  (strap_nvm_i),
        .wr_hit_i     (wr_hit),
        .wdata_i      (reg_wdata_i[WO_BITS-1:0]),
        .ctl_o        (ctl_q),
        .done_o       (done_q)
    );

    memmap_xlate #(
        .AW       (AW),
        .GAW      (GAW),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST),
        .INT_BANK (INT_BANK),
        .EXT_BANK (EXT_BANK)
    ) u_xl (
        .cpu_addr_i (cpu_addr_i),
        .hh_i       (ctl_q.hh),
        .nvm_i      (ctl_q.nvm),
        .hit_o      (win_hit_o),
        .glob_o     (glob_addr_o),
        .ext_o      (win_ext_o)
    );

endmodule

// File: rtl/memmap_ctrl_chk.sv
module memmap_ctrl_chk #(
    parameter int                AW       = 16,
    parameter int                DW       = 8,
    parameter int                GAW      = 23,
    parameter logic [GAW-AW-1:0] EXT_BANK = 7'h14
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     opmode_i,
    input logic           reg_wr_i,
    input logic [DW-1:0]  reg_rdata_o,
    input logic           ext_wr_o,
    input logic           win_hit_o,
    input logic [GAW-1:0] glob_addr_o,
    input logic           win_ext_o,
    input logic           emem_q,
    input logic           hh_q,
    input logic           nvm_q,
    input logic [1:0]     done_q
);

    // R1
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opmode_i != 2'b01) |-> (reg_rdata_o[DW-1:3] == '0));

    // R3
    emem_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(emem_q));

    // R4
    hh_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q[1] && !opmode_i[1]) |=> $stable(hh_q));

    // R4
    nvm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q[0] && !opmode_i[1]) |=> $stable(nvm_q));

    // R6
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit_o |-> (glob_addr_o == '0 && !win_ext_o));

    // R8
    relocated_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hh_q && win_hit_o) |-> (win_ext_o && glob_addr_o[GAW-1:AW] == EXT_BANK));

    // R9
    disabled_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nvm_q && win_hit_o) |-> win_ext_o);

    // R11
    mirror_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_o |-> (opmode_i == 2'b01 && reg_wr_i));

endmodule

bind memmap_ctrl memmap_ctrl_chk #(
    .AW       (AW),
    .DW       (DW),
    .GAW      (GAW),
    .EXT_BANK (EXT_BANK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opmode_i    (opmode_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rdata_o (reg_rdata_o),
    .ext_wr_o    (ext_wr_o),
    .win_hit_o   (win_hit_o),
    .glob_addr_o (glob_addr_o),
    .win_ext_o   (win_ext_o),
    .emem_q      (ctl_q.emem),
    .hh_q        (ctl_q.hh),
    .nvm_q       (ctl_q.nvm),
    .done_q      (done_q)
);

// File: tb/tb_memmap_ctrl.sv
`timescale 1ns/1ps
module tb_memmap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  opmode = 2'b00;
    logic        strap_emem = 1'b0;
    logic        strap_nvm = 1'b1;
    logic [15:0] reg_addr = 16'h0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h0;
    logic [7:0]  reg_rdata;
    logic [7:0]  ext_rdata = 8'h0;
    logic        ext_wr;
    logic [7:0]  ext_wdata;
    logic [15:0] cpu_addr = 16'h0;
    logic        win_hit;
    logic [22:0] glob_addr;
    logic        win_ext;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit ended   = 0;
    bit model_ok = 0;

    logic       m_emem, m_hh, m_nvm;
    logic [1:0] m_done;

    always #2.5 clk = ~clk;

    memmap_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .opmode_i     (opmode),
        .strap_emem_i (strap_emem),
        .strap_nvm_i  (strap_nvm),
        .reg_addr_i   (reg_addr),
        .reg_wr_i     (reg_wr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .ext_rdata_i  (ext_rdata),
        .ext_wr_o     (ext_wr),
        .ext_wdata_o  (ext_wdata),
        .cpu_addr_i   (cpu_addr),
        .win_hit_o    (win_hit),
        .glob_addr_o  (glob_addr),
        .win_ext_o    (win_ext)
    );

    function automatic logic exp_hit(input logic [15:0] a);
        return a >= 16'h4000 && a <= 16'h7FFF;
    endfunction

    function automatic logic [22:0] exp_glob(input logic [15:0] a, input logic hh);
        if (!exp_hit(a)) return 23'h0;
        return {(hh ? 7'h14 : 7'h7F), a};
    endfunction

    function automatic logic exp_ext(input logic [15:0] a, input logic hh, input logic nvm);
        return exp_hit(a) && (hh || !nvm);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] ra, input logic [1:0] m,
                                          input logic [7:0] ed);
        if (ra != 16'h0013) return 8'h00;
        if (m == 2'b01) return ed;
        return {5'b0, m_emem, m_hh, m_nvm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        string wt;
        if (exp_hit(cpu_addr)) wt = m_hh ? "R8" : (m_nvm ? "R7" : "R9");
        else                   wt = "R6";
        chk((reg_addr == 16'h0013 && opmode == 2'b01) ? "R10 rdata" : "R1 rdata",
            32'(reg_rdata), 32'(exp_rd(reg_addr, opmode, ext_rdata)));
        chk("R6 hit", 32'(win_hit), 32'(exp_hit(cpu_addr)));
        chk({wt, " glob"}, 32'(glob_addr), 32'(exp_glob(cpu_addr, m_hh)));
        chk({wt, " ext"}, 32'(win_ext), 32'(exp_ext(cpu_addr, m_hh, m_nvm)));
        chk("R11 ext_wr", 32'(ext_wr),
            32'(reg_wr && reg_addr == 16'h0013 && opmode == 2'b01));
        if (ext_wr) chk("R11 ext_wdata", 32'(ext_wdata), 32'(reg_wdata));
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_emem = strap_emem; m_hh = 1'b0; m_nvm = strap_nvm; m_done = 2'b00;
            model_ok = 1;
        end else if (reg_wr && reg_addr == 16'h0013) begin
            if (opmode[1]) begin
                m_hh = reg_wdata[1]; m_nvm = reg_wdata[0];
            end else begin
                if (!m_done[1]) begin m_hh  = reg_wdata[1]; m_done[1] = 1'b1; end
                if (!m_done[0]) begin m_nvm = reg_wdata[0]; m_done[0] = 1'b1; end
            end
        end
    endtask

    task automatic step(input logic r, input logic [1:0] m, input logic w,
                        input logic [15:0] ra, input logic [7:0] wd,
                        input logic [15:0] ca, input logic [7:0] ed);
        @(negedge clk);
        rst_n = r; opmode = m; reg_wr = w; reg_addr = ra; reg_wdata = wd;
        cpu_addr = ca; ext_rdata = ed;
        #1;
        if (model_ok) compare_all();
        @(posedge clk);
        #0.1;
        model_edge();
    endtask

    task automatic do_reset(input logic se, input logic sn);
        strap_emem = se; strap_nvm = sn;
        step(1'b0, 2'b00, 1'b0, 16'h0, 8'h0, 16'h0, 8'h0);
        step(1'b0, 2'b00, 1'b0, 16'h0, 8'h0, 16'h0, 8'h0);
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] d);
        step(1'b1, m, 1'b1, 16'h0013, d, 16'h0, 8'h5A);
    endtask

    task automatic expect_ctl(input string tag, input logic [2:0] e);
        step(1'b1, 2'b00, 1'b0, 16'h0013, 8'h0, 16'h0, 8'h0);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 16'h0013; opmode = 2'b00;
        #1;
        chk(tag, 32'(reg_rdata), 32'({5'b0, e}));
    endtask

    task automatic expect_win(input string tag, input logic [15:0] a,
                              input logic [22:0] eg, input logic ex);
        @(negedge clk);
        reg_wr = 1'b0; cpu_addr = a;
        #1;
        chk({tag, " glob"}, 32'(glob_addr), 32'(eg));
        chk({tag, " ext"}, 32'(win_ext), 32'(ex));
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R2: reset loads straps, hh clear
        do_reset(1'b1, 1'b0);
        expect_ctl("R2 straps 1/0", 3'b100);
        expect_win("R9 disabled", 16'h4000, 23'h7F4000, 1'b1);
        do_reset(1'b0, 1'b1);
        expect_ctl("R2 straps 0/1", 3'b001);
        expect_win("R7 internal", 16'h7FFF, 23'h7F7FFF, 1'b0);
        expect_win("R6 below", 16'h3FFF, 23'h0, 1'b0);
        expect_win("R6 above", 16'h8000, 23'h0, 1'b0);
        // R3 + R4: first normal write lands, bit 2 untouched
        wr(2'b00, 8'hFE);
        expect_ctl("R3 R4 first write", 3'b010);
        expect_win("R8 relocated", 16'h4000, 23'h144000, 1'b1);
        wr(2'b00, 8'h01);
        expect_ctl("R4 second write ignored", 3'b010);
        wr(2'b01, 8'h03);
        expect_ctl("R4 emul write ignored", 3'b010);
        // R5: special writes unlimited
        wr(2'b10, 8'h05);
        expect_ctl("R5 special write", 3'b001);
        wr(2'b11, 8'hFB);
        expect_ctl("R5 special again", 3'b011);
        // R5: special writes do not consume the once chance
        do_reset(1'b1, 1'b1);
        wr(2'b10, 8'h00);
        expect_ctl("R5 special first", 3'b100);
        wr(2'b01, 8'h02);
        expect_ctl("R5 R11 emul once after special", 3'b110);
        wr(2'b00, 8'h01);
        expect_ctl("R4 locked after emul", 3'b110);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic        r;
            logic [15:0] ra, ca;
            r = ($urandom % 120) != 0;
            if (!r) begin strap_emem = $urandom % 2; strap_nvm = $urandom % 2; end
            ra = ($urandom % 2) ? 16'h0013 : 16'($urandom);
            case ($urandom % 4)
                0: ca = 16'h3FFF + 16'($urandom % 3);
                1: ca = 16'h7FFE + 16'($urandom % 3);
                default: ca = 16'($urandom);
            endcase
            step(r, 2'($urandom), ($urandom % 3) == 0, ra, 8'($urandom), ca, 8'($urandom));
        end

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule